// File: doc/BRIEF.md
# Filtered GPIO Edge-Interrupt Controller

This block watches a port of general-purpose input pins and raises one shared, active-low interrupt whenever a pin shows a change that software has asked to hear about. Every pin brings its raw level through a two-flop synchronizer. It can then pass through an optional glitch filter, which accepts a new level only after the level has held for a programmed number of clock samples. Edge logic runs on the accepted level. One status bit per pin records each qualifying event.

Each pin has five configuration bits: direction, interrupt enable, rising enable, falling enable and filter enable. The rising and falling enables pick one of four edge modes. In any-change mode (both enables clear), a pending flag also withdraws by itself when the pin goes back to the level that the port-state read last captured. In the other three modes, only that read clears the flag. The port-state read is a one-cycle strobe. It clears the status bits and latches a snapshot of the accepted pin levels.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, `status_o` = 0, `snap_o` = 0 and `irq_n_o` = 1. The configuration comes up with every pin an input, interrupts disabled, both edge enables clear and the filter enabled on every pin.
- R2: A pin whose direction bit is 0 (output) or whose interrupt enable is 0 never sets its status bit. Its status bit reads 0 from the cycle after either bit goes to 0.
- R3: In any-change mode (rise = 0, fall = 0), an accepted level change to a value different from the pin's snapshot bit sets its status bit.
- R4: In any-change mode, a set status bit clears when the accepted level returns to the pin's snapshot bit, with no read.
- R5: In rising mode (rise = 1, fall = 0), only a 0-to-1 accepted change sets the status bit. A falling change neither sets nor clears it.
- R6: In falling mode (rise = 0, fall = 1), only a 1-to-0 accepted change sets the status bit.
- R7: In both-edges mode (rise = 1, fall = 1), either change sets the status bit. Returning to the previous level does not clear it.
- R8: A cycle with `state_rd_i` high clears every status bit and loads `snap_o` with the accepted levels. A bit whose qualifying edge falls in that same cycle stays set.
- R9: With the filter enabled, the synchronized level must hold for FILT_HOLD consecutive clock samples (8 by default) before it is accepted. A pulse of 2 cycles never sets a status bit, and a pulse of 12 cycles does.
- R10: With the filter disabled, every synchronized change is accepted on the next clock. A 2-cycle pulse therefore sets a status bit.
- R11: `irq_n_o` is low exactly while at least one status bit is set.
- R12: Status bit i, snapshot bit i and configuration bit i all belong to `pin_i[i]`. `cfg_sel_i` selects which configuration word `cfg_data_i` writes: 0 direction, 1 interrupt enable, 2 rising enable, 3 falling enable, 4 filter enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NPINS | Raw asynchronous pin levels |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration word select |
| cfg_data_i | input | NPINS | Configuration write data, one bit per pin |
| state_rd_i | input | 1 | One-cycle port-state read strobe |
| snap_o | output | NPINS | Accepted levels latched at the last read |
| status_o | output | NPINS | Per-pin interrupt status |
| irq_n_o | output | 1 | Shared active-low interrupt |

## Verification
The checker watches every cycle for five things:
- masked pins never hold a status bit;
- no status bit rises without a change in the accepted level;
- a read leaves only same-cycle events standing;
- the snapshot loads on a read and holds otherwise;
- an accepted level only ever moves to the synchronized value.

Three kinds of behaviour show only in the bench's directed scenarios:
- the mode-dependent set and clear rules, including self-clearing in any-change mode and the absence of it in both-edges mode;
- the filter's reject and pass widths, tested with 2-cycle and 12-cycle pulses;
- the ordering when a read and an edge arrive in the same cycle.

// File: rtl/gpio_irq_pkg.sv
// Package: shared selects and edge-mode encoding for the GPIO interrupt engine.
package gpio_irq_pkg;

    // Configuration word selects used by cfg_sel_i.
    typedef enum logic [2:0] {
        CFG_DIR  = 3'd0,
        CFG_IEN  = 3'd1,
        CFG_RISE = 3'd2,
        CFG_FALL = 3'd3,
        CFG_FILT = 3'd4
    } cfg_sel_e;

    // Edge mode formed as {rise_en, fall_en}.
    typedef enum logic [1:0] {
        MODE_ANY  = 2'b00,
        MODE_FALL = 2'b01,
        MODE_RISE = 2'b10,
        MODE_BOTH = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/gpio_irq_cfg.sv
// Module: gpio_irq_cfg
// Holds the five per-pin configuration words. A write strobe together with
// a select loads one word. Assumes cfg_wr_i is synchronous to clk.
// Reset state: all inputs, interrupts off, edge enables off, filters on.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [2:0]       sel_i,
    input  logic [NPINS-1:0] data_i,
    output logic [NPINS-1:0] dir_o,
    output logic [NPINS-1:0] ien_o,
    output logic [NPINS-1:0] rise_o,
    output logic [NPINS-1:0] fall_o,
    output logic [NPINS-1:0] filt_o
);

    // Configuration word update on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_o  <= '1;
            ien_o  <= '0;
            rise_o <= '0;
            fall_o <= '0;
            filt_o <= '1;
        end else if (wr_i) begin
            case (cfg_sel_e'(sel_i))
                CFG_DIR:  dir_o  <= data_i;
                CFG_IEN:  ien_o  <= data_i;
                CFG_RISE: rise_o <= data_i;
                CFG_FALL: fall_o <= data_i;
                CFG_FILT: filt_o <= data_i;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Multi-stage flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din_i,
    output logic [NPINS-1:0] dout_o
);

    logic [NPINS-1:0] stg [STAGES];

    // Shift the raw levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout_o = stg[STAGES-1];

endmodule

// File: rtl/gpio_glitch_filter.sv
// Module: gpio_glitch_filter
// One-pin level filter. When enabled, a new synchronized level is accepted
// only after it differs from the accepted level for HOLD consecutive
// samples. Any sample that matches again restarts the count. When disabled,
// the level is accepted on the next clock. Assumes HOLD >= 2.
module gpio_glitch_filter #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic din_i,
    output logic lvl_o
);

    localparam int             CW   = (HOLD > 2) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0]  LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt;

    // Count consecutive disagreeing samples and accept the level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o <= 1'b0;
            cnt   <= '0;
        end else if (!en_i) begin
            lvl_o <= din_i;
            cnt   <= '0;
        end else if (din_i == lvl_o) begin
            cnt   <= '0;
        end else if (cnt == LAST) begin
            lvl_o <= din_i;
            cnt   <= '0;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/gpio_pin_irq.sv
// Module: gpio_pin_irq
// Edge detect, status bit and snapshot for one pin. The input is the
// accepted (filtered) level. arm_i is high when the pin is an input with its
// interrupt enabled. A set event wins over a read or a self-clear.
module gpio_pin_irq
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic arm_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    input  logic rd_i,
    output logic snap_o,
    output logic stat_o
);

    logic       lvl_d;
    logic       rose, fell, hit, heal;
    edge_mode_e mode;

    assign mode = edge_mode_e'({rise_en_i, fall_en_i});
    assign rose = lvl_i & ~lvl_d;
    assign fell = ~lvl_i & lvl_d;

    // Decode which events set and which self-clear for the current mode.
    always_comb begin
        hit  = 1'b0;
        heal = 1'b0;
        case (mode)
            MODE_ANY: begin
                hit  = (rose | fell) & (lvl_i != snap_o);
                heal = (lvl_i == snap_o);
            end
            MODE_RISE: hit = rose;
            MODE_FALL: hit = fell;
            MODE_BOTH: hit = rose | fell;
            default:   hit = 1'b0;
        endcase
    end

    // Remember the previous accepted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl_i;
    end

    // Status bit: masked to zero, set wins, then read or self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            stat_o <= 1'b0;
        else if (!arm_i)       stat_o <= 1'b0;
        else if (hit)          stat_o <= 1'b1;
        else if (rd_i || heal) stat_o <= 1'b0;
    end

    // Snapshot of the accepted level, loaded by a port-state read.
    always_ff @(posedge clk) begin
        if (!rst_n)    snap_o <= 1'b0;
        else if (rd_i) snap_o <= lvl_i;
    end

endmodule

// File: rtl/gpio_edge_irq.sv
// Module: gpio_edge_irq (top)
// Per-pin input-change interrupt engine. Each pin runs through a
// synchronizer, an optional glitch filter and mode-driven edge logic. The
// resulting status bits feed one shared active-low interrupt. Assumes
// state_rd_i is a one-cycle strobe synchronous to clk.
module gpio_edge_irq #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_HOLD   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic             cfg_wr_i,
    input  logic [2:0]       cfg_sel_i,
    input  logic [NPINS-1:0] cfg_data_i,
    input  logic             state_rd_i,
    output logic [NPINS-1:0] snap_o,
    output logic [NPINS-1:0] status_o,
    output logic             irq_n_o
);

    logic [NPINS-1:0] cfg_dir, cfg_ien, cfg_rise, cfg_fall, cfg_filt;
    logic [NPINS-1:0] sync_lv, acc_lv, arm;

    gpio_irq_cfg #(.NPINS(NPINS)) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr_i),
        .sel_i  (cfg_sel_i),
        .data_i (cfg_data_i),
        .dir_o  (cfg_dir),
        .ien_o  (cfg_ien),
        .rise_o (cfg_rise),
        .fall_o (cfg_fall),
        .filt_o (cfg_filt)
    );

    gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (pin_i),
        .dout_o (sync_lv)
    );

    assign arm = cfg_dir & cfg_ien;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_glitch_filter #(.HOLD(FILT_HOLD)) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (cfg_filt[g]),
            .din_i (sync_lv[g]),
            .lvl_o (acc_lv[g])
        );

        gpio_pin_irq i_irq (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_i     (acc_lv[g]),
            .arm_i     (arm[g]),
            .rise_en_i (cfg_rise[g]),
            .fall_en_i (cfg_fall[g]),
            .rd_i      (state_rd_i),
            .snap_o    (snap_o[g]),
            .stat_o    (status_o[g])
        );
    end

    assign irq_n_o = ~|status_o;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
// Module: gpio_edge_irq_chk
// Cycle-by-cycle properties of the interrupt engine, bound into the top.
module gpio_edge_irq_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd,
    input logic [NPINS-1:0] sync_lv,
    input logic [NPINS-1:0] acc_lv,
    input logic [NPINS-1:0] arm,
    input logic [NPINS-1:0] status,
    input logic [NPINS-1:0] snap
);

    logic [NPINS-1:0] lvl_q;

    // Private copy of the previous accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= acc_lv;
    end

    // R2: disarmed pins hold no status.
    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(arm)) == '0));

    // R3: a newly set status bit needs an accepted change one cycle earlier.
    p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(acc_lv ^ lvl_q)) == '0));

    // R8: after a read only same-cycle events remain set.
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> ((status & ~$past(acc_lv ^ lvl_q)) == '0));

    // R8: the snapshot loads the accepted levels on a read.
    p_snap_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (snap == $past(acc_lv)));

    // R8: the snapshot holds between reads.
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(snap));

    // R9: an accepted level only ever moves to the synchronized value.
    p_filter_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((acc_lv ^ $past(acc_lv)) & (acc_lv ^ $past(sync_lv))) == '0));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (state_rd_i),
    .sync_lv (sync_lv),
    .acc_lv  (acc_lv),
    .arm     (arm),
    .status  (status_o),
    .snap    (snap_o)
);

// File: tb/test_gpio_edge_irq.sv
// Directed bench for gpio_edge_irq: one task per scenario.
module test_gpio_edge_irq;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_i = '0;
    logic         cfg_wr_i = 1'b0;
    logic [2:0]   cfg_sel_i = '0;
    logic [N-1:0] cfg_data_i = '0;
    logic         state_rd_i = 1'b0;
    logic [N-1:0] snap_o, status_o;
    logic         irq_n_o;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] pins = '0;

    always #2.5 clk = ~clk;

    gpio_edge_irq i_gpio_edge_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_sel_i  (cfg_sel_i),
        .cfg_data_i (cfg_data_i),
        .state_rd_i (state_rd_i),
        .snap_o     (snap_o),
        .status_o   (status_o),
        .irq_n_o    (irq_n_o)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [N-1:0] d);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic setpin(input int i, input logic v);
        pins[i] = v;
        pin_i = pins;
    endtask

    task automatic do_read();
        @(negedge clk);
        state_rd_i = 1'b1;
        @(negedge clk);
        state_rd_i = 1'b0;
    endtask

    task automatic pulse(input int i, input int len);
        @(negedge clk);
        setpin(i, 1'b1);
        cyc(len);
        setpin(i, 1'b0);
    endtask

    // R1: reset values, then default filter-on, any-change behaviour.
    task automatic t_reset_defaults();
        chk("R1 status after reset", status_o, '0);
        chk("R1 irq_n after reset", {7'd0, irq_n_o}, 8'h01);
        chk("R1 snap after reset", snap_o, '0);
        cfg(3'd1, 8'hFF);
        pulse(0, 2);
        cyc(20);
        chk("R1 R9 filter on by default rejects 2-cycle pulse", status_o, '0);
        @(negedge clk);
        setpin(0, 1'b1);
        cyc(12);
        chk("R3 R9 12-cycle level accepted", status_o, 8'h01);
        chk("R11 irq_n low while pending", {7'd0, irq_n_o}, 8'h00);
        setpin(0, 1'b0);
        cyc(16);
        chk("R4 self-clear on return to snapshot", status_o, '0);
        chk("R11 irq_n high when clear", {7'd0, irq_n_o}, 8'h01);
    endtask

    // R8 R3 R4: read clears and loads snapshot; self-clear follows new snapshot.
    task automatic t_read_any();
        @(negedge clk);
        setpin(0, 1'b1);
        cyc(16);
        chk("R3 set on change", status_o, 8'h01);
        do_read();
        chk("R8 read clears status", status_o, '0);
        chk("R8 snapshot loaded", snap_o, pins);
        setpin(0, 1'b0);
        cyc(16);
        chk("R3 set on change away from snapshot 1", status_o, 8'h01);
        setpin(0, 1'b1);
        cyc(16);
        chk("R4 self-clear on return to 1", status_o, '0);
    endtask

    // R5 R10: rising mode, filter off.
    task automatic t_rising();
        cfg(3'd4, 8'h00);
        cfg(3'd2, 8'hFF);
        cfg(3'd3, 8'h00);
        do_read();
        pulse(2, 2);
        cyc(8);
        chk("R5 R10 2-cycle pulse sets with filter off", status_o, 8'h04);
        do_read();
        chk("R8 read clears rising", status_o, '0);
        @(negedge clk);
        setpin(2, 1'b1);
        cyc(8);
        chk("R5 rising sets", status_o, 8'h04);
        do_read();
        setpin(2, 1'b0);
        cyc(8);
        chk("R5 falling ignored", status_o, '0);
    endtask

    // R6: falling mode.
    task automatic t_falling();
        cfg(3'd2, 8'h00);
        cfg(3'd3, 8'hFF);
        @(negedge clk);
        setpin(3, 1'b1);
        cyc(8);
        chk("R6 rising ignored", status_o, '0);
        setpin(3, 1'b0);
        cyc(8);
        chk("R6 falling sets", status_o, 8'h08);
        do_read();
    endtask

    // R7: both edges, no self-clear.
    task automatic t_both();
        cfg(3'd2, 8'hFF);
        @(negedge clk);
        setpin(4, 1'b1);
        cyc(8);
        chk("R7 rise sets", status_o, 8'h10);
        do_read();
        setpin(4, 1'b0);
        cyc(8);
        chk("R7 fall sets", status_o, 8'h10);
        do_read();
        chk("R8 snapshot in both mode", snap_o, pins);
        setpin(4, 1'b1);
        cyc(8);
        setpin(4, 1'b0);
        cyc(8);
        chk("R7 no self-clear on return", status_o, 8'h10);
        do_read();
    endtask

    // R9 R12: filter back on in rising mode; pulse widths and bit mapping.
    task automatic t_filter_rise();
        cfg(3'd3, 8'h00);
        cfg(3'd4, 8'hFF);
        pulse(5, 2);
        cyc(20);
        chk("R9 2-cycle pulse rejected", status_o, '0);
        pulse(5, 12);
        cyc(20);
        chk("R9 R12 12-cycle pulse sets bit 5 only", status_o, 8'h20);
        do_read();
    endtask

    // R2 R12: output and disabled pins stay quiet; disarming drops status.
    task automatic t_masking();
        cfg(3'd2, 8'h00);
        cfg(3'd4, 8'h00);
        cfg(3'd0, 8'hFE);
        cfg(3'd1, 8'hFD);
        do_read();
        @(negedge clk);
        setpin(0, 1'b0);
        cyc(8);
        chk("R2 output pin masked", status_o, '0);
        setpin(1, 1'b1);
        cyc(8);
        chk("R2 disabled pin masked", status_o, '0);
        setpin(6, 1'b1);
        cyc(8);
        chk("R12 pin 6 maps to bit 6", status_o, 8'h40);
        cfg(3'd0, 8'hBE);
        cyc(2);
        chk("R2 status drops when pin made output", status_o, '0);
        cfg(3'd0, 8'hFF);
        cfg(3'd1, 8'hFF);
    endtask

    // R8: edge qualifying in the read cycle survives the read.
    task automatic t_same_cycle();
        cfg(3'd2, 8'hFF);
        do_read();
        @(negedge clk);
        setpin(5, 1'b1);
        cyc(8);
        chk("R5 pin 5 pending before read", status_o, 8'h20);
        setpin(7, 1'b1);
        cyc(3);
        state_rd_i = 1'b1;
        @(negedge clk);
        state_rd_i = 1'b0;
        chk("R8 same-cycle set wins, others cleared", status_o, 8'h80);
        chk("R8 snapshot at same-cycle read", snap_o, pins);
        do_read();
        chk("R8 later read clears", status_o, '0);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_defaults();
        t_read_any();
        t_rising();
        t_falling();
        t_both();
        t_filter_rise();
        t_masking();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule